// File: doc/BRIEF.md
# Transmit DMA Channel Control, Status and Error Flags

This block holds the control and status state for eight transmit DMA channels. Software programs each channel through a configuration word that selects a run mode and gates request generation. Each channel holds at most one pending activation command in a one-entry request buffer. It also keeps a credit counter. Credit returns raise the counter and issued requests lower it. A request leaves the channel only when a command is held, the mode allows running, requests are enabled and at least one credit remains.

A shared status word shows, per channel, whether the request buffer is empty and whether a request is waiting to go out. A shared error word latches faults and keeps them until software clears them. The faults are: a command arriving at a full buffer, a FIFO-full indication while credits are still outstanding, and two global faults (internal address error, host word-count mismatch). A flag is cleared by writing 1 to its bit. A set event in the same cycle as the clear wins.

Reads are combinational from the address. Writes take effect at the next clock edge. Moving data and choosing which channel to activate are done by neighbouring logic.

Top module: `txdma_chan_status`

## Requirements
- R1: After reset, all configuration words and credit counters read 0, the status word reads 0xFFFF0000, the error word reads 0, and no request is issued.
- R2: The configuration word of channel c is at byte address 0x20*c. Bits 31:30 hold the mode (00 off, 01 pause after the current frame, 10 run, 11 treated as off), bit 3 enables requests, and every other bit reads 0.
- R3: `reqIssue[c]` is 1 in a cycle exactly when channel c holds a command, its mode is 01 or 10, bit 3 is set and its credit is nonzero. The buffer is empty in the next cycle.
- R4: The credit counter of channel c reads at address 0x20*c+4 in bits 3:0. It rises by one per credit return and falls by one per issued request. A return arriving while the counter is 15 is ignored.
- R5: Issuing a request while the mode is 01 sets the mode to 00 at the next edge, unless a configuration write lands in the same cycle.
- R6: The status word at 0x100 has bit 24+c set when channel c's buffer is empty, and bit 16+c set when channel c has no request waiting (not both holding a command and running).
- R7: An activation command for channel c while its buffer is full sets error bit 9+c, and the command is dropped.
- R8: A FIFO-full indication for channel c while its credit is nonzero sets error bit c.
- R9: The address-error input sets error bit 31, and the word-count error input sets error bit 30.
- R10: Writing the error word at 0x104 clears every flag whose data bit is 1 and leaves the others. A set in the same cycle wins over the clear.
- R11: Writes to the status word, to credit counter addresses and to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| actCmd | input | 8 | Per-channel activation command |
| fifoFull | input | 8 | Per-channel FIFO-full indication |
| creditRet | input | 8 | Per-channel credit return |
| addrErr | input | 1 | Internal address error event |
| countErr | input | 1 | Host word-count mismatch event |
| reqIssue | output | 8 | Per-channel request issued this cycle |

## Verification
A wrong buffer-held bit or credit count shows on `reqIssue` in the cycle it goes wrong, provided the channel is running. It also shows on the next read of the status word or the credit address. A missed or spurious error flag stays latched, so it shows on every later read of the error word until it is cleared. The bench therefore reads a varying address in every cycle and compares that read and all issue outputs against a reference model. A fault therefore surfaces within a few cycles of its cause.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  // The shared status and error words give one bit per channel in 8-bit fields.
  localparam int NUM_CH    = 8;
  localparam int ADDR_W    = 12;
  localparam int CH_STRIDE = 32;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 12'h100;
  localparam logic [ADDR_W-1:0] ERR_ADDR  = 12'h104;
  localparam int ACT_ERR_LSB = 9;
  localparam logic [31:0] ERR_MASK = 32'hC001_FEFF;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EOF = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef struct packed {
    logic [NUM_CH-1:0] cfgWr;
    logic [31:0]       errClr;
    logic [1:0]        newMode;
    logic              newReqEn;
  } strobe_t;
endpackage

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    for (int c = 0; c < NUM_CH; c++)
      stb.cfgWr[c] = wrEn && (addr == ADDR_W'(c * CH_STRIDE));
    stb.errClr   = (wrEn && addr == ERR_ADDR) ? (wdata & ERR_MASK) : 32'h0;
    stb.newMode  = wdata[31:30];
    stb.newReqEn = wdata[3];
  end
endmodule

// File: rtl/txdma_datapath.sv
module txdma_datapath
  import txdma_pkg::*;
#(
  parameter int CRED_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] actCmd,
  input  logic [NUM_CH-1:0] fifoFull,
  input  logic [NUM_CH-1:0] creditRet,
  input  logic              addrErr,
  input  logic              countErr,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] reqIssue,
  output logic [NUM_CH-1:0] heldVec,
  output logic [NUM_CH-1:0] creditNz,
  output logic [31:0]       errVec
);
  localparam logic [CRED_W-1:0] CRED_MAX = {CRED_W{1'b1}};

  logic [1:0]        modeArr [NUM_CH];
  logic [CRED_W-1:0] credArr [NUM_CH];
  logic [NUM_CH-1:0] enVec, runVec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mode_e             mode;
    logic              reqEn, held;
    logic [CRED_W-1:0] cred;
    logic              run, issue, retOk;

    assign run   = (mode == MODE_RUN || mode == MODE_EOF) && reqEn;
    assign issue = held && run && (cred != '0);
    assign retOk = creditRet[g] && (cred != CRED_MAX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mode  <= MODE_OFF;
        reqEn <= 1'b0;
        held  <= 1'b0;
        cred  <= '0;
      end else begin
        if (stb.cfgWr[g]) begin
          mode  <= mode_e'(stb.newMode);
          reqEn <= stb.newReqEn;
        end else if (issue && mode == MODE_EOF) begin
          mode <= MODE_OFF;
        end
        if (issue)          held <= 1'b0;
        else if (actCmd[g]) held <= 1'b1;
        cred <= cred + CRED_W'(retOk) - CRED_W'(issue);
      end
    end

    assign modeArr[g]  = mode;
    assign credArr[g]  = cred;
    assign enVec[g]    = reqEn;
    assign runVec[g]   = run;
    assign heldVec[g]  = held;
    assign creditNz[g] = (cred != '0);
    assign reqIssue[g] = issue;
  end

  // Sticky error word: set events override a simultaneous write-1 clear.
  logic [31:0] errSet;
  always_comb begin
    errSet     = '0;
    errSet[31] = addrErr;
    errSet[30] = countErr;
    for (int c = 0; c < NUM_CH; c++) begin
      errSet[ACT_ERR_LSB + c] = actCmd[c] && heldVec[c];
      errSet[c]               = fifoFull[c] && creditNz[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errVec <= '0;
    else       errVec <= (errVec & ~stb.errClr) | errSet;
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(c * CH_STRIDE))
        rdData = {modeArr[c], 26'b0, enVec[c], 3'b0};
      if (addr == ADDR_W'(c * CH_STRIDE + 4))
        rdData = 32'(credArr[c]);
    end
    if (addr == STAT_ADDR) rdData = {~heldVec, ~(heldVec & runVec), 16'h0};
    if (addr == ERR_ADDR)  rdData = errVec;
  end
endmodule

// File: rtl/txdma_chan_status.sv
module txdma_chan_status
  import txdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdData,
  input  logic [7:0]  actCmd,
  input  logic [7:0]  fifoFull,
  input  logic [7:0]  creditRet,
  input  logic        addrErr,
  input  logic        countErr,
  output logic [7:0]  reqIssue
);
  strobe_t     stb;
  logic [7:0]  heldVec, creditNz;
  logic [31:0] errVec;

  txdma_ctrl u_ctrl (
    .wrEn(wrEn), .addr(addr), .wdata(wdata), .stb(stb)
  );

  txdma_datapath #(.CRED_W(4)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr),
    .actCmd(actCmd), .fifoFull(fifoFull), .creditRet(creditRet),
    .addrErr(addrErr), .countErr(countErr),
    .rdData(rdData), .reqIssue(reqIssue),
    .heldVec(heldVec), .creditNz(creditNz), .errVec(errVec)
  );
endmodule

// File: rtl/txdma_chan_status_chk.sv
module txdma_chan_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [11:0] addr,
  input logic [31:0] wdata,
  input logic [7:0]  actCmd,
  input logic [7:0]  fifoFull,
  input logic        addrErr,
  input logic [7:0]  reqIssue,
  input logic [7:0]  heldVec,
  input logic [7:0]  creditNz,
  input logic [31:0] errVec
);
  logic [31:0] clrVec;
  assign clrVec = (wrEn && addr == 12'h104) ? wdata : 32'h0;

  for (genvar g = 0; g < 8; g++) begin : g_prop
    // R3: an issued request empties the buffer at the next edge
    assert_issue_empties_R3: assert property (@(posedge clk) disable iff (!rstN)
      reqIssue[g] |=> !heldVec[g]);
    // R7: command into a full buffer raises its flag
    assert_act_err_R7: assert property (@(posedge clk) disable iff (!rstN)
      (actCmd[g] && heldVec[g]) |=> errVec[9 + g]);
    // R8: FIFO full with credits outstanding raises its flag
    assert_credit_err_R8: assert property (@(posedge clk) disable iff (!rstN)
      (fifoFull[g] && creditNz[g]) |=> errVec[g]);
  end

  // R9: address error latches bit 31
  assert_addr_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |=> errVec[31]);

  // R10: a flag only drops when its bit was written with 1
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((errVec & ~clrVec) != 32'h0) |=> (($past(errVec) & ~$past(clrVec) & ~errVec) == 32'h0));
endmodule

bind txdma_chan_status txdma_chan_status_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .actCmd(actCmd), .fifoFull(fifoFull), .addrErr(addrErr),
  .reqIssue(reqIssue), .heldVec(heldVec), .creditNz(creditNz), .errVec(errVec)
);

// File: tb/txdma_chan_status_bench.sv
module txdma_chan_status_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdData;
  logic [7:0]  actCmd = '0, fifoFull = '0, creditRet = '0, reqIssue;
  logic        addrErr = 1'b0, countErr = 1'b0;

  int errors = 0, checks = 0;
  bit done = 0;

  int mMode [8], mEn [8], mHeld [8], mCred [8];
  logic [31:0] mErr;

  always #2 clk = ~clk;

  txdma_chan_status u_txdma_chan_status (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdData(rdData), .actCmd(actCmd), .fifoFull(fifoFull),
    .creditRet(creditRet), .addrErr(addrErr), .countErr(countErr),
    .reqIssue(reqIssue)
  );

  function automatic bit mRun(int c);
    return (mMode[c] == 1 || mMode[c] == 2) && mEn[c] != 0;
  endfunction

  function automatic bit mIssue(int c);
    return mHeld[c] != 0 && mRun(c) && mCred[c] != 0;
  endfunction

  function automatic logic [31:0] mRead(logic [11:0] a);
    logic [31:0] v = '0;
    for (int c = 0; c < 8; c++) begin
      if (a == 12'(c * 32))     v = {2'(mMode[c]), 26'b0, 1'(mEn[c]), 3'b0};
      if (a == 12'(c * 32 + 4)) v = 32'(mCred[c]);
    end
    if (a == 12'h100)
      for (int c = 0; c < 8; c++) begin
        v[24 + c] = (mHeld[c] == 0);
        v[16 + c] = !(mHeld[c] != 0 && mRun(c));
      end
    if (a == 12'h104) v = mErr;
    return v;
  endfunction

  function automatic string tagFor(logic [11:0] a);
    if (a == 12'h100) return "R6";
    if (a == 12'h104) return "R7/R8/R9/R10";
    if (a < 12'h100 && a[2]) return "R4/R11";
    if (a < 12'h100 && a[4:0] == 5'd0) return "R2/R5";
    return "R11";
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h got=%h expected=%h", tag, addr, got, exp);
    end
  endtask

  task automatic modelInit();
    for (int c = 0; c < 8; c++) begin
      mMode[c] = 0; mEn[c] = 0; mHeld[c] = 0; mCred[c] = 0;
    end
    mErr = '0;
  endtask

  task automatic modelStep();
    logic [31:0] setV = '0, clrV = '0;
    bit iss [8];
    for (int c = 0; c < 8; c++) iss[c] = mIssue(c);
    if (wrEn && addr == 12'h104) clrV = wdata & 32'hC001_FEFF;
    setV[31] = addrErr;
    setV[30] = countErr;
    for (int c = 0; c < 8; c++) begin
      if (actCmd[c] && mHeld[c] != 0) setV[9 + c] = 1'b1;
      if (fifoFull[c] && mCred[c] != 0) setV[c] = 1'b1;
      if (creditRet[c] && mCred[c] != 15) mCred[c]++;
      if (iss[c]) mCred[c]--;
      if (wrEn && addr == 12'(c * 32)) begin
        mMode[c] = int'(wdata[31:30]); mEn[c] = int'(wdata[3]);
      end else if (iss[c] && mMode[c] == 1) mMode[c] = 0;
      if (iss[c]) mHeld[c] = 0;
      else if (actCmd[c]) mHeld[c] = 1;
    end
    mErr = (mErr & ~clrV) | setV;
  endtask

  // One clock: inputs already driven after a falling edge; compare, step model.
  task automatic cycle();
    logic [7:0] expIss;
    #1;
    for (int c = 0; c < 8; c++) expIss[c] = mIssue(c);
    check("R3", 32'(reqIssue), 32'(expIss));
    check(tagFor(addr), rdData, mRead(addr));
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic drive(bit w, logic [11:0] a, logic [31:0] d,
                       logic [7:0] act, logic [7:0] ff, logic [7:0] cr);
    wrEn = w; addr = a; wdata = d; actCmd = act; fifoFull = ff; creditRet = cr;
    addrErr = 1'b0; countErr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelInit();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    drive(0, 12'h100, 0, 0, 0, 0); #1;
    check("R1", rdData, 32'hFFFF_0000);
    check("R1", 32'(reqIssue), 32'h0);
    drive(0, 12'h104, 0, 0, 0, 0); cycle();
    drive(0, 12'h0E4, 0, 0, 0, 0); cycle();
    // R2: configuration with junk in reserved bits
    for (int c = 0; c < 4; c++) begin
      drive(1, 12'(c * 32), 32'hBFFF_FFFF, 0, 0, 0); cycle();
    end
    drive(1, 12'h080, 32'h4000_0008, 0, 0, 0); cycle();  // ch4 pause after frame (R5)
    drive(1, 12'h0C0, 32'h8000_0000, 0, 0, 0); cycle();  // ch6 run, requests off
    // R4: credits, saturation on ch7 (off)
    for (int i = 0; i < 20; i++) begin
      drive(0, 12'h0E4, 0, 0, 0, 8'h80); cycle();
    end
    drive(0, 12'h004, 0, 0, 0, 8'hFF); cycle();
    // R3/R5: commands, ch4 returns to off after its issue
    drive(0, 12'h080, 0, 8'h5F, 0, 0); cycle();
    drive(0, 12'h100, 0, 8'h5F, 0, 0); cycle();          // R7: repeats into full buffers
    drive(0, 12'h080, 0, 0, 0, 0); cycle();
    // R8/R10: set wins over a same-cycle clear on ch7
    drive(1, 12'h104, 32'hFFFF_FFFF, 0, 8'h80, 0); cycle();
    drive(0, 12'h104, 0, 0, 0, 0); cycle();
    // R9
    drive(0, 12'h104, 0, 0, 0, 0); addrErr = 1'b1; countErr = 1'b1; cycle();
    drive(1, 12'h104, 32'h4000_0000, 0, 0, 0); cycle();
    // R11: writes with no effect
    drive(1, 12'h100, 32'h0, 0, 0, 0); cycle();
    drive(1, 12'h0E4, 32'h0, 0, 0, 0); cycle();
    drive(1, 12'h108, 32'hFFFF_FFFF, 0, 0, 0); cycle();
    drive(0, 12'h0E4, 0, 0, 0, 0); cycle();
    // Mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      int sel = int'($urandom % 19);
      if (sel < 8)       a = 12'(sel * 32);
      else if (sel < 16) a = 12'((sel - 8) * 32 + 4);
      else if (sel == 16) a = 12'h100;
      else if (sel == 17) a = 12'h104;
      else                a = 12'h10C;
      drive(($urandom % 8) == 0, a, $urandom,
            8'($urandom & $urandom), 8'($urandom & $urandom & $urandom),
            8'($urandom & $urandom));
      addrErr  = ($urandom % 64) == 0;
      countErr = ($urandom % 64) == 0;
      cycle();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule